// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Control Register Bank

This block holds a set of 32-bit control words behind a simple request bus (valid, write, byte address, access size, write data). The address window is split in two halves. The lower half holds plain words: a write overwrites the word and a read returns it. The upper half holds aliased words. Each aliased word owns four consecutive word addresses. The first is the word itself. The other three are shadow addresses that apply a bitwise OR, a bitwise AND-NOT or a bitwise XOR to the stored word in a single write. Software can therefore change individual control bits without a read-modify-write sequence.

Each word loads a parameterised default value at reset. On words marked as PLL controls, a lock status bit is also forced high on top of that default. The bank returns one response per request, one cycle later. An illegal request produces an error pulse and leaves all state unchanged.

Top module: `sca_reg_bank`

## Requirements
- R1: During reset, and after it, every response output is zero. After reset, the plain words read 0x0401167F, 0x00018D00, 0x24860324 and 0x00000000 at byte offsets 0x0, 0x4, 0x8 and 0xC. The aliased words read 0x80013001, 0x1018101B, 0x80013063 and 0x04000000. For words 0 and 2, the bit 31 lock flag has been ORed onto the defaults 0x00013001 and 0x00013063.
- R2: A write to the SET shadow (one word above an aliased base) ORs the write data into the base word.
- R3: A write to the CLEAR shadow (two words above the base) clears every base bit that is 1 in the write data.
- R4: A write to the TOGGLE shadow (three words above the base) XORs the write data into the base word.
- R5: A read of any SET, CLEAR or TOGGLE shadow returns the current value of its base word.
- R6: A write to a plain word, or to an aliased base address, replaces all 32 bits.
- R7: Plain word n sits at byte offset 4n. Aliased word n has its base at byte offset 0x4000 + 16n. The window is 0x8000 bytes (15-bit address).
- R8: The following requests raise rsp_err for exactly one cycle, return read data 0 and change no word: a size other than 4 bytes, an address with either low bit set, a plain word index of 4 or more, or an aliased word index of 4 or more.
- R9: Every request produces rsp_valid on the next cycle and never otherwise. Read data is registered and valid in that cycle. Write responses carry read data 0.
- R10: Shadow writes to one word on back-to-back cycles each apply to the value left by the previous write, so no update is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address inside the window |
| req_bytes | input | 3 | Access size in bytes; only 4 is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_err | output | 1 | Request was illegal |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |

## Verification
The bench first reads every word after reset. This separates the lock-bit forcing from the plain defaults. It then writes to the base, SET, CLEAR and TOGGLE addresses with data that overlaps the stored bits partly. Because of that overlap, the OR, AND-NOT, XOR and replace results all differ from one another, so a swapped or mis-offset shadow operation shows up as a different word. A burst of shadow writes on consecutive cycles exposes any lost update. Bad sizes, misaligned addresses and out-of-range indices in both halves are each followed by a readback, which shows that nothing changed.

// File: rtl/sca_pkg.sv
package sca_pkg;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } op_e;

   function automatic logic [DATA_W-1:0] apply_op(op_e op,
                                                  logic [DATA_W-1:0] cur,
                                                  logic [DATA_W-1:0] wd);
      logic [DATA_W-1:0] res;
      case (op)
         OP_SET:    res = cur | wd;
         OP_CLEAR:  res = cur & ~wd;
         OP_TOGGLE: res = cur ^ wd;
         default:   res = wd;
      endcase
      return res;
   endfunction
endpackage

// File: rtl/sca_addr_decode.sv
module sca_addr_decode
   import sca_pkg::*;
#(
   parameter int N_PLAIN = 4,
   parameter int N_ALIAS = 4,
   parameter int ADDR_W  = 15,
   localparam int GW      = ADDR_W - 3,
   localparam int PIDX_W  = (N_PLAIN > 1) ? $clog2(N_PLAIN) : 1,
   localparam int AIDX_W  = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        bytes,
   output logic              hit_plain,
   output logic              hit_alias,
   output logic [PIDX_W-1:0] plain_idx,
   output logic [AIDX_W-1:0] alias_idx,
   output op_e               op,
   output logic              err
);
   // word offset inside the selected half of the window
   logic [GW-1:0]   word;
   logic [GW-3:0]   areg;
   logic            upper;
   logic            legal_shape;

   assign word  = addr[ADDR_W-2:2];
   assign areg  = word[GW-1:2];
   assign upper = addr[ADDR_W-1];

   assign legal_shape = (bytes == 3'd4) && (addr[1:0] == 2'b00);

   assign hit_plain = legal_shape && !upper && (word < GW'(N_PLAIN));
   assign hit_alias = legal_shape &&  upper && (areg < (GW-2)'(N_ALIAS));
   assign err       = !(hit_plain || hit_alias);

   assign plain_idx = word[PIDX_W-1:0];
   assign alias_idx = areg[AIDX_W-1:0];
   assign op        = upper ? op_e'(word[1:0]) : OP_WRITE;
endmodule

// File: rtl/sca_word.sv
module sca_word
   import sca_pkg::*;
#(
   parameter logic [DATA_W-1:0] RESET_VAL = '0,
   parameter bit                ALIASED   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  op_e               op,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] nxt;

   generate
      if (ALIASED) begin : g_alias
         assign nxt = apply_op(op, q, wdata);
      end else begin : g_plain
         assign nxt = (op == OP_WRITE) ? wdata : q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RESET_VAL;
      else if (wr_en) q <= nxt;
   end
endmodule

// File: rtl/sca_reg_bank.sv
module sca_reg_bank
   import sca_pkg::*;
#(
   parameter int N_PLAIN  = 4,
   parameter int N_ALIAS  = 4,
   parameter int ADDR_W   = 15,
   parameter int LOCK_BIT = 31,
   parameter logic [N_PLAIN*DATA_W-1:0] PLAIN_INIT =
      {32'h0000_0000, 32'h2486_0324, 32'h0001_8D00, 32'h0401_167F},
   parameter logic [N_ALIAS*DATA_W-1:0] ALIAS_INIT =
      {32'h0400_0000, 32'h0001_3063, 32'h1018_101B, 32'h0001_3001},
   parameter logic [N_ALIAS-1:0] PLL_MASK = 4'b0101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_bytes,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [31:0]       rsp_rdata
);
   localparam int PIDX_W = (N_PLAIN > 1) ? $clog2(N_PLAIN) : 1;
   localparam int AIDX_W = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1;
   localparam logic [DATA_W-1:0] LOCK_FLAG = DATA_W'(1) << LOCK_BIT;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("sca_reg_bank: ADDR_W too small");
      end
      if (N_PLAIN < 1 || N_PLAIN >= (1 << (ADDR_W - 3))) begin : g_bad_plain
         $error("sca_reg_bank: N_PLAIN does not fit its half window");
      end
      if (N_ALIAS < 1 || N_ALIAS >= (1 << (ADDR_W - 5))) begin : g_bad_alias
         $error("sca_reg_bank: N_ALIAS does not fit its half window");
      end
      if (LOCK_BIT < 0 || LOCK_BIT >= DATA_W) begin : g_bad_lock
         $error("sca_reg_bank: LOCK_BIT outside the word");
      end
   endgenerate

   logic              hit_plain, hit_alias, dec_err;
   logic [PIDX_W-1:0] plain_idx;
   logic [AIDX_W-1:0] alias_idx;
   op_e               dec_op;

   sca_addr_decode #(
      .N_PLAIN(N_PLAIN), .N_ALIAS(N_ALIAS), .ADDR_W(ADDR_W)
   ) u_dec (
      .addr      (req_addr),
      .bytes     (req_bytes),
      .hit_plain (hit_plain),
      .hit_alias (hit_alias),
      .plain_idx (plain_idx),
      .alias_idx (alias_idx),
      .op        (dec_op),
      .err       (dec_err)
   );

   logic [DATA_W-1:0] plain_q [N_PLAIN];
   logic [DATA_W-1:0] alias_q [N_ALIAS];
   logic              wr_go;

   assign wr_go = req_valid && req_write;

   genvar gi;
   generate
      for (gi = 0; gi < N_PLAIN; gi++) begin : g_plain
         sca_word #(
            .RESET_VAL (PLAIN_INIT[gi*DATA_W +: DATA_W]),
            .ALIASED   (1'b0)
         ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_go && hit_plain && (plain_idx == PIDX_W'(gi))),
            .op    (OP_WRITE),
            .wdata (req_wdata),
            .q     (plain_q[gi])
         );
      end
      for (gi = 0; gi < N_ALIAS; gi++) begin : g_alias
         localparam logic [DATA_W-1:0] RV =
            ALIAS_INIT[gi*DATA_W +: DATA_W] | (PLL_MASK[gi] ? LOCK_FLAG : '0);
         sca_word #(
            .RESET_VAL (RV),
            .ALIASED   (1'b1)
         ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_go && hit_alias && (alias_idx == AIDX_W'(gi))),
            .op    (dec_op),
            .wdata (req_wdata),
            .q     (alias_q[gi])
         );
      end
   endgenerate

   logic [DATA_W-1:0] rd_sel;
   always_comb begin
      rd_sel = '0;
      if (hit_plain)      rd_sel = plain_q[plain_idx];
      else if (hit_alias) rd_sel = alias_q[alias_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && dec_err;
         rsp_rdata <= (req_valid && !req_write) ? rd_sel : '0;
      end
   end
endmodule

// File: rtl/sca_reg_bank_chk.sv
module sca_reg_bank_chk #(
   parameter int ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [2:0]        req_bytes,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [31:0]       rsp_rdata
);
   assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_write_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 32'd0));

   assert_bad_size_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_bytes != 3'd4) |=> rsp_err);

   assert_misaligned_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);

   assert_err_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

   assert_err_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err && !$past(req_valid && (req_bytes != 3'd4))) |-> rsp_valid);
endmodule

bind sca_reg_bank sca_reg_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_bytes (req_bytes),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata)
);

// File: tb/sca_reg_bank_tb.sv
module sca_reg_bank_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [14:0] req_addr = '0;
   logic [2:0]  req_bytes = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // behavioural reference state
   logic [31:0] m_plain [4];
   logic [31:0] m_alias [4];

   sca_reg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic compare(input string tag, input logic ev, input logic ee,
                          input logic [31:0] ed);
      n_cmp++;
      if (rsp_valid !== ev || rsp_err !== ee || rsp_rdata !== ed) begin
         n_bad++;
         $display("FAIL %s: got valid=%0b err=%0b data=%08h, expected valid=%0b err=%0b data=%08h",
                  tag, rsp_valid, rsp_err, rsp_rdata, ev, ee, ed);
      end
   endtask

   // one clock: drive a request, step the model, compare the response
   task automatic cyc(input string tag, input bit v, input bit w,
                      input logic [14:0] a, input logic [2:0] b,
                      input logic [31:0] d);
      logic        ev, ee;
      logic [31:0] ed, cur;
      bit          ok;
      int          wi, ri, op;
      req_valid = v; req_write = w; req_addr = a; req_bytes = b; req_wdata = d;
      ev = v; ee = 0; ed = 0; ok = 0; wi = 0; ri = 0; op = 0; cur = 0;
      if (v) begin
         if (b == 3'd4 && a[1:0] == 2'b00) begin
            if (a < 15'h4000) begin
               wi = int'(a) / 4;
               if (wi < 4) begin ok = 1; cur = m_plain[wi]; end
            end else begin
               wi = (int'(a) - 'h4000) / 4;
               ri = wi / 4; op = wi % 4;
               if (ri < 4) begin ok = 1; cur = m_alias[ri]; end
            end
         end
         ee = !ok;
         if (ok && !w) ed = cur;
         if (ok && w) begin
            if (a < 15'h4000) m_plain[wi] = d;
            else case (op)
               1: m_alias[ri] = cur | d;
               2: m_alias[ri] = cur & ~d;
               3: m_alias[ri] = cur ^ d;
               default: m_alias[ri] = d;
            endcase
         end
      end
      @(posedge clk);
      @(negedge clk);
      compare(tag, ev, ee, ed);
   endtask

   task automatic rd(input string tag, input logic [14:0] a);
      cyc(tag, 1, 0, a, 3'd4, 32'd0);
   endtask

   task automatic wr(input string tag, input logic [14:0] a, input logic [31:0] d);
      cyc(tag, 1, 1, a, 3'd4, d);
   endtask

   task automatic idle(input string tag);
      cyc(tag, 0, 0, 15'd0, 3'd4, 32'd0);
   endtask

   initial begin
      m_plain[0] = 32'h0401167F; m_plain[1] = 32'h00018D00;
      m_plain[2] = 32'h24860324; m_plain[3] = 32'h00000000;
      m_alias[0] = 32'h80013001; m_alias[1] = 32'h1018101B;
      m_alias[2] = 32'h80013063; m_alias[3] = 32'h04000000;

      repeat (3) @(negedge clk);
      compare("R1 outputs in reset", 0, 0, 32'd0);
      rst_n = 1'b1;
      idle("R1 idle after reset");

      // R1 / R7: defaults and mapping
      for (int i = 0; i < 4; i++) rd("R1 plain default", 15'(4*i));
      for (int i = 0; i < 4; i++) rd("R1 alias default with lock", 15'('h4000 + 16*i));
      // R5: shadow reads return base
      rd("R5 set shadow read", 15'h4004);
      rd("R5 clear shadow read", 15'h4018);
      rd("R5 toggle shadow read", 15'h402C);
      rd("R5 set shadow read word3", 15'h4034);
      // R6: full replace
      wr("R6 plain write", 15'h0004, 32'hDEADBEEF);
      rd("R6 plain readback", 15'h0004);
      wr("R6 alias base write", 15'h4010, 32'h12345678);
      rd("R6 alias base readback", 15'h4010);
      // R2, R3, R4 with partial overlap
      wr("R2 set", 15'h4014, 32'h0F0F0000);
      rd("R2 set result", 15'h4010);
      wr("R3 clear", 15'h4018, 32'h12000078);
      rd("R3 clear result", 15'h4010);
      wr("R4 toggle", 15'h401C, 32'hFFFF0000);
      rd("R4 toggle result", 15'h4010);
      rd("R5 toggle shadow after updates", 15'h401C);
      wr("R3 clear lock bit", 15'h4008, 32'h80000000);
      rd("R3 lock cleared", 15'h4000);
      wr("R2 set lock bit", 15'h4004, 32'h80000001);
      rd("R2 lock set", 15'h4000);
      // R10: back-to-back shadow writes
      wr("R10 set", 15'h4034, 32'h00000001);
      wr("R10 clear", 15'h4038, 32'h04000000);
      wr("R10 toggle", 15'h403C, 32'h00000003);
      wr("R10 set again", 15'h4034, 32'h00F00000);
      rd("R10 combined result", 15'h4030);
      // R8: illegal accesses change nothing
      cyc("R8 short write", 1, 1, 15'h4020, 3'd2, 32'hFFFFFFFF);
      cyc("R8 misaligned write", 1, 1, 15'h4022, 3'd4, 32'hFFFFFFFF);
      cyc("R8 short read", 1, 0, 15'h4020, 3'd1, 32'd0);
      wr("R8 plain index out of range", 15'h0010, 32'hFFFFFFFF);
      wr("R8 alias index out of range", 15'h4040, 32'hFFFFFFFF);
      wr("R8 far plain address", 15'h2000, 32'hFFFFFFFF);
      rd("R8 read out of range", 15'h7FFC);
      rd("R8 alias word unchanged", 15'h4020);
      rd("R8 plain word unchanged", 15'h000C);
      // R9: idle gives no response, then back-to-back reads
      idle("R9 no response when idle");
      rd("R9 read latency", 15'h0008);
      rd("R9 back-to-back read", 15'h0000);
      idle("R9 trailing idle");

      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule